// File: doc/BRIEF.md
# Table-Driven Sequencer

This block is a finite state machine with no next-state gates. Its transition function lives in a 512-entry by 8-bit lookup memory. On every rising clock edge, the 6-bit condition vector and the 3-bit current state code are joined into a 9-bit index. The word stored at that index is captured on the same edge. Its low three bits become the new state, and its upper five bits become registered flags that belong to that new state. The state register feeds straight back into the index. There is no pipeline stage between the read and the state, so the machine takes exactly one transition per clock.

The machine has seven states, named ST_A to ST_G, with codes 001 to 111. Code 000 is a void code and is never held. All ordinary transitions are defined by the table contents that software loads through a simple write port. That loading normally happens while reset is held. The block itself adds only two fixed transitions:

- **Reset transition:** a reset, from any state, goes to ST_A.
- **Recovery transition:** a table entry whose next-state field is 000 sends the machine to ST_A. It also sets a sticky error flag.

Top module: `rom_seq_fsm`

## Requirements
- R1: The table index is formed as {cond[5:0], state[2:0]}. The state code occupies index bits [2:0] and the condition vector occupies bits [8:3].
- R2: In the first cycle after synchronous reset is released, the state is 001 (ST_A), the flags are zero and the error flag is low.
- R3: While reset is held, the state stays 001 and the flags and error flag stay zero, whatever the condition input and the table contents.
- R4: On each clock edge out of reset, the state becomes bits [2:0] of the table word at {cond, state} sampled at that edge. This is one transition per clock with no extra delay.
- R5: On that same edge, the flags become bits [7:3] of that same table word.
- R6: If the fetched word has next-state field 000, the edge loads state 001 and flags zero and sets the error flag. The error flag stays set until the next reset.
- R7: A write (enable, 9-bit index, 8-bit word) is accepted both during reset and while running. A lookup of the same index on the same edge still returns the old word, and every later lookup returns the new word.
- R8: Out of reset the state output only ever shows codes 001 to 111, never 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond | input | 6 | Condition vector, part of the table index |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 9 | Table index to write |
| wr_data | input | 8 | Word to write: {flags[4:0], next_state[2:0]} |
| state_o | output | 3 | Current state code |
| flags_o | output | 5 | Registered flags of the current state |
| illegal_o | output | 1 | Sticky flag, set when the table returned state 000 |

## Verification
The bench loads a table in which the two low condition bits select one of four behaviours:

| cond[1:0] | Behaviour |
|---|---|
| 00 | hold |
| 01 | step up with wrap |
| 10 | step down with wrap |
| 11 | jump to the code in cond[4:2] |

Each flag word also records the condition that led to it. With this table, an error in how the index bits are ordered shows up as a wrong state or wrong flags.

The tests cover the following cases:

- **All-zero conditions** tell a held state apart from a stale register.
- **All-one conditions** and the down-wrap from 001 exercise the index extremes.
- **A long pseudo-random walk** against a reference copy of the table separates one-per-clock stepping from any delayed feedback.
- **A write to the index being read in the same cycle** distinguishes old-word-then-new-word ordering.
- **An injected 000 entry** separates recovery from a plain transition and checks that the error flag is sticky.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_VOID = 3'd0,
        ST_A    = 3'd1,
        ST_B    = 3'd2,
        ST_C    = 3'd3,
        ST_D    = 3'd4,
        ST_E    = 3'd5,
        ST_F    = 3'd6,
        ST_G    = 3'd7
    } state_e;

    localparam state_e RESET_STATE = ST_A;
endpackage

// File: rtl/rsf_addr_join.sv
module rsf_addr_join
    import rsf_pkg::*;
#(
    parameter int COND_W = 6,
    localparam int ADDR_W = COND_W + STATE_W
) (
    input  logic [COND_W-1:0]  cond,
    input  state_e             state,
    output logic [ADDR_W-1:0]  addr
);
    // State in the low bits, conditions above (R1)
    always_comb begin
        addr = {cond, state};
    end
endmodule

// File: rtl/rsf_table.sv
module rsf_table #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write lands at the edge; a lookup at the same edge sees the old word (R7)
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Lookup is captured by the state register at the edge, forming the synchronous read
    always_comb begin
        rd_data = mem[rd_addr];
    end
endmodule

// File: rtl/rsf_state_reg.sv
module rsf_state_reg
    import rsf_pkg::*;
#(
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STATE_W-1:0] rd_next,
    input  logic [FLAG_W-1:0] rd_flags,
    output state_e            state,
    output logic [FLAG_W-1:0] flags,
    output logic              illegal
);
    state_e            nxt;
    logic              void_hit;
    logic [FLAG_W-1:0] nxt_flags;

    always_comb begin
        nxt       = RESET_STATE;
        void_hit  = 1'b0;
        nxt_flags = rd_flags;
        unique case (rd_next)
            3'd0: begin
                nxt       = RESET_STATE;
                void_hit  = 1'b1;
                nxt_flags = '0;
            end
            3'd1: nxt = ST_A;
            3'd2: nxt = ST_B;
            3'd3: nxt = ST_C;
            3'd4: nxt = ST_D;
            3'd5: nxt = ST_E;
            3'd6: nxt = ST_F;
            3'd7: nxt = ST_G;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RESET_STATE;
        end else begin
            state <= nxt;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            illegal <= 1'b0;
        end else begin
            flags   <= nxt_flags;
            illegal <= illegal | void_hit;
        end
    end
endmodule

// File: rtl/rom_seq_fsm.sv
module rom_seq_fsm
    import rsf_pkg::*;
#(
    parameter int COND_W = 6,
    parameter int FLAG_W = 5,
    localparam int ADDR_W = COND_W + STATE_W,
    localparam int DATA_W = FLAG_W + STATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] cond,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [STATE_W-1:0] state_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              illegal_o
);
    state_e            cur_state;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;

    rsf_addr_join #(.COND_W(COND_W)) u_join (
        .cond  (cond),
        .state (cur_state),
        .addr  (rd_addr)
    );

    rsf_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    rsf_state_reg #(.FLAG_W(FLAG_W)) u_sreg (
        .clk      (clk),
        .rst      (rst),
        .rd_next  (rd_word[STATE_W-1:0]),
        .rd_flags (rd_word[DATA_W-1:STATE_W]),
        .state    (cur_state),
        .flags    (flags_o),
        .illegal  (illegal_o)
    );

    always_comb begin
        state_o = cur_state;
    end
endmodule

// File: rtl/rsf_checker.sv
module rsf_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rd_word,
    input logic [2:0] state_o,
    input logic [4:0] flags_o,
    input logic       illegal_o
);
    a_r2_reset_exit: assert property (@(posedge clk)
        $fell(rst) |-> (state_o == 3'd1 && flags_o == 5'd0 && !illegal_o));

    a_r4_follow_table: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_word[2:0]) != 3'd0) |-> state_o == $past(rd_word[2:0]));

    a_r5_flags_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_word[2:0]) != 3'd0) |-> flags_o == $past(rd_word[7:3]));

    a_r6_void_recover: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_word[2:0]) == 3'd0) |-> (state_o == 3'd1 && flags_o == 5'd0 && illegal_o));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> illegal_o);

    a_r8_no_void: assert property (@(posedge clk) disable iff (rst)
        state_o != 3'd0);
endmodule

bind rom_seq_fsm rsf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_word   (rd_word),
    .state_o   (state_o),
    .flags_o   (flags_o),
    .illegal_o (illegal_o)
);

// File: tb/rom_seq_fsm_test.sv
`timescale 1ns/1ps
module rom_seq_fsm_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cond = '0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] state_o;
    logic [4:0] flags_o;
    logic       illegal_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] ref_tbl [512];
    logic [2:0] ms = 3'd1;
    logic [4:0] mf = 5'd0;
    logic       mill = 1'b0;

    always #10 clk = ~clk;

    rom_seq_fsm uut (
        .clk(clk), .rst(rst), .cond(cond),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .state_o(state_o), .flags_o(flags_o), .illegal_o(illegal_o)
    );

    function automatic logic [7:0] entry_of(input logic [5:0] c, input logic [2:0] s);
        logic [2:0] n;
        case (c[1:0])
            2'd0: n = s;
            2'd1: n = (s == 3'd7) ? 3'd1 : s + 3'd1;
            2'd2: n = (s <= 3'd1) ? 3'd7 : s - 3'd1;
            default: n = (c[4:2] == 3'd0) ? 3'd1 : c[4:2];
        endcase
        if (n == 3'd0) n = 3'd1;
        return {n, c[1:0], n};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " state"}, state_o, ms);
        check({tag, " flags"}, flags_o, mf);
        check({tag, " illegal"}, illegal_o, mill);
    endtask

    // One clock of running: drive at negedge, model, compare at next negedge
    task automatic step(input logic [5:0] c, input string tag);
        logic [7:0] w;
        cond = c;
        w = ref_tbl[{c, ms}];
        if (w[2:0] == 3'd0) begin
            ms = 3'd1; mf = 5'd0; mill = 1'b1;
        end else begin
            ms = w[2:0]; mf = w[7:3];
        end
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic t_load_and_reset();
        rst = 1'b1;
        for (int a = 0; a < 512; a++) begin
            wr_en = 1'b1;
            wr_addr = 9'(a);
            wr_data = entry_of(6'(a >> 3), 3'(a));
            ref_tbl[a] = wr_data;
            @(negedge clk);
        end
        wr_en = 1'b0;
        // R3: reset held with varying conditions
        for (int i = 0; i < 3; i++) begin
            cond = 6'(i * 21 + 5);
            @(negedge clk);
            ms = 3'd1; mf = 5'd0; mill = 1'b0;
            check_all("R3 reset held");
        end
        rst = 1'b0;
        // R2: first cycle after release, checked before the first running edge
        check_all("R2 reset exit");
    endtask

    task automatic t_patterns();
        step(6'h00, "R4 hold zero cond");
        step(6'h02, "R4 down wrap from 001");
        step(6'h3F, "R1 all-ones jump to 111");
        step(6'h01, "R4 up wrap from 111");
        step(6'h0F, "R1 jump to 011");
        step(6'h12, "R5 down step flags");
        step(6'h00, "R5 hold flags");
    endtask

    task automatic t_random_walk();
        for (int i = 0; i < 300; i++) begin
            step(6'($urandom_range(63)), "R4 R5 random walk");
        end
    endtask

    task automatic t_runtime_write();
        logic [2:0] s0;
        logic [2:0] n2;
        step(6'h00, "R7 setup");
        s0 = ms;
        n2 = (s0 == 3'd3) ? 3'd5 : 3'd3;
        wr_en = 1'b1;
        wr_addr = {6'd0, s0};
        wr_data = {5'h15, n2};
        step(6'h00, "R7 same-edge read old");
        ref_tbl[{6'd0, s0}] = {5'h15, n2};
        wr_en = 1'b0;
        step(6'h00, "R7 later read new");
    endtask

    task automatic t_void_entry();
        wr_en = 1'b1;
        wr_addr = {6'd1, ms};
        wr_data = 8'hF8;
        step(6'h00, "R6 setup");
        ref_tbl[{6'd1, ms}] = 8'hF8;
        wr_en = 1'b0;
        step(6'h01, "R6 void recovery");
        check("R8 not void", (state_o != 3'd0) ? 1 : 0, 1);
        for (int i = 0; i < 5; i++) begin
            step(6'($urandom_range(63)), "R6 sticky");
        end
    endtask

    task automatic t_mid_reset();
        step(6'h1F, "R4 before reset");
        rst = 1'b1;
        @(negedge clk);
        ms = 3'd1; mf = 5'd0; mill = 1'b0;
        check_all("R3 mid-run reset");
        rst = 1'b0;
        step(6'h01, "R2 R4 first step after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_load_and_reset();
        t_patterns();
        t_random_walk();
        t_runtime_write();
        t_void_entry();
        t_mid_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule